// File: doc/BRIEF.md
# Transmit Frame Staging Buffer

This block gathers one outgoing Ethernet frame from 32-bit word writes into a 2048-byte staging memory. The first word written into an empty buffer carries the payload byte count in its low half. The rest of the words supply the destination, source and type fields, then the payload and, if software wants to supply one, a trailing check sequence. The block holds the frame until it is launched, then streams it out byte by byte to a downstream MAC serializer over a valid/ready handshake.

A frame can be launched in two ways. In the first, it starts by itself after a write once the fill level passes a programmable 6-bit threshold and the buffer holds the whole frame. The number of bytes needed for a whole frame depends on whether the MAC appends the check sequence. In the second, a one-cycle transmit strobe launches whatever is stored. The streamed frame begins after the 2-byte count field and is the payload plus 14 header bytes long. When padding is enabled, short frames are extended with zero bytes to 60. One-cycle events report a rejected length and an emptied buffer to an interrupt register outside the block.

Top module: `txpkt_fifo`

## Requirements
- R1: After reset `o_valid`, `busy`, `evt_txerr` and `evt_txemp` are low and `thr_q` reads 0x3F.
- R2: In a word written while the buffer is empty, bits 15:0 are the payload length. The bits are stored little-endian, so they sit at byte offsets 0 and 1. If that value is above 2032, nothing is stored and `evt_txerr` pulses high in the cycle after the write.
- R3: An accepted word is stored as four bytes, with bits 7:0 at the lowest offset. It is stored only when the fill level plus 4 does not exceed 2048. Otherwise it is dropped.
- R4: A frame is complete when the fill level is at least min(length + 16 + (crc_auto ? 0 : 4), 2048).
- R5: The threshold is active only when `thr_q` is below 0x3F, and it is met when the fill level is at least 32*thr_q + 4. After each accepted write, a launch starts only when the threshold is met and the frame is complete. Otherwise the block returns to idle without output.
- R6: A `tx_req` pulse while `busy` is low launches the frame whatever the fill level, threshold or completeness.
- R7: The launched frame is the stored bytes from offset 2 onward, length + 14 bytes long, and capped at 2046. With `pad_en` set it is stretched to 60 bytes. A byte at an offset not below length + 16, or not below the fill level, is sent as 0x00, so any supplied check bytes are not sent.
- R8: While `o_valid` is high and `o_ready` low, `o_data` and `o_last` hold. `o_last` is high only on the final byte of the frame.
- R9: When the final byte is accepted, the fill level returns to zero, `evt_txemp` pulses high in the next cycle, and `busy` drops.
- R10: An `err_ack` pulse empties the buffer, so the next word written is taken as a new length word.
- R11: `busy` is high in the cycle after each accepted write and for the whole time a frame is sent. A word presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to store |
| busy | output | 1 | Writes are not accepted this cycle |
| tx_req | input | 1 | Transmit command strobe |
| err_ack | input | 1 | Acknowledge of the length error; empties the buffer |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| crc_auto | input | 1 | MAC appends the check sequence |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 6 | New threshold value |
| thr_q | output | 6 | Current threshold value |
| o_valid | output | 1 | Output byte valid |
| o_data | output | 8 | Output byte |
| o_last | output | 1 | Final byte of the frame |
| o_ready | input | 1 | Downstream accepts the byte |
| evt_txerr | output | 1 | Length error event pulse |
| evt_txemp | output | 1 | Buffer emptied after send |

## Verification
On every cycle the assertions check these behaviours. The fill level stays word-aligned and within 2048 bytes. A rejected length word leaves the fill level unchanged. A stalled output byte holds still. Output appears only while the block is busy. The fill level is zero when the empty event fires. Only the bench scenarios can show the rest. These are the exact word on which an automatic launch fires for each threshold and check-sequence setting, the byte content of sent frames with padding and zeroed tail bytes, the drop of words past the buffer end, and the effect of the error acknowledge and of writes made while busy. All of these need a model of the stored bytes that compares every accepted output byte.

// File: rtl/txpkt_pkg.sv
package txpkt_pkg;
  localparam int LEN_W = 16;
  localparam int NW    = LEN_W + 2;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_CHECK = 2'd1,
    C_SEND  = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/txpkt_store.sv
module txpkt_store #(
  parameter int WORDS = 512,
  parameter int WA_W  = 9
) (
  input  logic            clk,
  input  logic            we,
  input  logic [WA_W-1:0] waddr,
  input  logic [31:0]     wdata,
  input  logic [WA_W-1:0] raddr,
  output logic [31:0]     rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/txpkt_ctrl.sv
module txpkt_ctrl
  import txpkt_pkg::*;
#(
  parameter int BUF_BYTES   = 2048,
  parameter int MAX_PAYLOAD = 2032,
  parameter int THR_W       = 6,
  parameter int BC_W        = 12,
  parameter int WA_W        = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic             tx_req,
  input  logic             err_ack,
  input  logic             crc_auto,
  input  logic [THR_W-1:0] thr,
  input  logic             send_done,
  output logic             mem_we,
  output logic [WA_W-1:0]  mem_waddr,
  output logic [31:0]      mem_wdata,
  output logic [BC_W-1:0]  fill,
  output logic [LEN_W-1:0] pay_len,
  output logic             launch,
  output logic             busy,
  output logic             evt_txerr,
  output logic             evt_txemp
);
  localparam logic [THR_W-1:0] THR_OFF = '1;

  ctrl_state_e state;
  logic [BC_W-1:0]  fill_q;
  logic [LEN_W-1:0] len_q;
  logic accept, first, too_long, has_room;
  logic [NW-1:0] need_raw, need, thr_lim;
  logic complete, thr_hit;

  always_comb begin
    accept   = wr_valid && (state == C_IDLE) && !tx_req;
    first    = (fill_q == '0);
    too_long = first && (wr_data[LEN_W-1:0] > LEN_W'(MAX_PAYLOAD));
    has_room = (NW'(fill_q) + NW'(4)) <= NW'(BUF_BYTES);
    need_raw = NW'(len_q) + NW'(16) + (crc_auto ? NW'(0) : NW'(4));
    need     = (need_raw > NW'(BUF_BYTES)) ? NW'(BUF_BYTES) : need_raw;
    complete = NW'(fill_q) >= need;
    thr_lim  = NW'({thr, 5'b00000}) + NW'(4);
    thr_hit  = (thr != THR_OFF) && (NW'(fill_q) >= thr_lim);
    launch   = ((state == C_IDLE) && tx_req) ||
               ((state == C_CHECK) && thr_hit && complete);
  end

  assign mem_we    = accept && !too_long && has_room;
  assign mem_waddr = fill_q[WA_W+1:2];
  assign mem_wdata = wr_data;
  assign fill      = fill_q;
  assign pay_len   = len_q;
  assign busy      = (state != C_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= C_IDLE;
      fill_q    <= '0;
      len_q     <= '0;
      evt_txerr <= 1'b0;
      evt_txemp <= 1'b0;
    end else begin
      evt_txerr <= accept && too_long;
      evt_txemp <= send_done;
      unique case (state)
        C_IDLE: begin
          if (tx_req)                   state <= C_SEND;
          else if (accept && !too_long) state <= C_CHECK;
        end
        C_CHECK: state <= (thr_hit && complete) ? C_SEND : C_IDLE;
        C_SEND:  if (send_done) state <= C_IDLE;
        default: state <= C_IDLE;
      endcase
      if (err_ack || send_done) fill_q <= '0;
      else if (mem_we)          fill_q <= fill_q + BC_W'(4);
      if (mem_we && first) len_q <= wr_data[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/txpkt_stream.sv
module txpkt_stream
  import txpkt_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int HDR_BYTES = 14,
  parameter int MIN_FRAME = 60,
  parameter int BC_W      = 12,
  parameter int WA_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             pad_en,
  input  logic [BC_W-1:0]  fill,
  input  logic [31:0]      rdata,
  output logic [WA_W-1:0]  raddr,
  output logic             o_valid,
  output logic [7:0]       o_data,
  output logic             o_last,
  input  logic             o_ready,
  output logic             done
);
  logic            active;
  logic [BC_W-1:0] ptr, end_ptr, lim;
  logic [WA_W-1:0] q_addr;
  logic [NW-1:0]   base, padded, flen, lim_len;
  logic [7:0]      lane_byte;
  logic            q_ok, take, feed;

  always_comb begin
    base    = NW'(pay_len) + NW'(HDR_BYTES);
    padded  = (pad_en && (base < NW'(MIN_FRAME))) ? NW'(MIN_FRAME) : base;
    flen    = (padded > NW'(BUF_BYTES - 2)) ? NW'(BUF_BYTES - 2) : padded;
    lim_len = NW'(pay_len) + NW'(HDR_BYTES + 2);
  end

  assign raddr     = ptr[WA_W+1:2];
  assign q_ok      = (q_addr == raddr);
  assign lane_byte = rdata[{ptr[1:0], 3'b000} +: 8];
  assign take      = o_valid && o_ready;
  assign feed      = active && (ptr != end_ptr) && q_ok && (!o_valid || o_ready);
  assign done      = take && o_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ptr     <= '0;
      end_ptr <= '0;
      lim     <= '0;
      q_addr  <= '0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
    end else begin
      q_addr <= raddr;
      if (launch) begin
        active  <= 1'b1;
        ptr     <= BC_W'(2);
        end_ptr <= BC_W'(flen + NW'(2));
        lim     <= (NW'(fill) < lim_len) ? fill : BC_W'(lim_len);
      end else begin
        if (done) active <= 1'b0;
        if (feed) begin
          o_valid <= 1'b1;
          o_data  <= (ptr < lim) ? lane_byte : 8'h00;
          o_last  <= ((ptr + BC_W'(1)) == end_ptr);
          ptr     <= ptr + BC_W'(1);
        end else if (take) begin
          o_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
  import txpkt_pkg::*;
#(
  parameter int BUF_BYTES   = 2048,
  parameter int MAX_PAYLOAD = 2032,
  parameter int HDR_BYTES   = 14,
  parameter int MIN_FRAME   = 60,
  parameter int THR_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             busy,
  input  logic             tx_req,
  input  logic             err_ack,
  input  logic             pad_en,
  input  logic             crc_auto,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_wdata,
  output logic [THR_W-1:0] thr_q,
  output logic             o_valid,
  output logic [7:0]       o_data,
  output logic             o_last,
  input  logic             o_ready,
  output logic             evt_txerr,
  output logic             evt_txemp
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int WA_W  = $clog2(WORDS);
  localparam int BC_W  = $clog2(BUF_BYTES + 1);

  logic             mem_we;
  logic [WA_W-1:0]  mem_waddr, mem_raddr;
  logic [31:0]      mem_wdata, mem_rdata;
  logic [BC_W-1:0]  fill;
  logic [LEN_W-1:0] pay_len;
  logic             launch, send_done;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= '1;
    else if (thr_we) thr_q <= thr_wdata;
  end

  txpkt_store #(.WORDS(WORDS), .WA_W(WA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  txpkt_ctrl #(
    .BUF_BYTES(BUF_BYTES), .MAX_PAYLOAD(MAX_PAYLOAD), .THR_W(THR_W),
    .BC_W(BC_W), .WA_W(WA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_req(tx_req), .err_ack(err_ack), .crc_auto(crc_auto), .thr(thr_q),
    .send_done(send_done), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .fill(fill), .pay_len(pay_len), .launch(launch),
    .busy(busy), .evt_txerr(evt_txerr), .evt_txemp(evt_txemp)
  );

  txpkt_stream #(
    .BUF_BYTES(BUF_BYTES), .HDR_BYTES(HDR_BYTES), .MIN_FRAME(MIN_FRAME),
    .BC_W(BC_W), .WA_W(WA_W)
  ) u_stream (
    .clk(clk), .rst(rst), .launch(launch), .pay_len(pay_len),
    .pad_en(pad_en), .fill(fill), .rdata(mem_rdata), .raddr(mem_raddr),
    .o_valid(o_valid), .o_data(o_data), .o_last(o_last),
    .o_ready(o_ready), .done(send_done)
  );
endmodule

// File: rtl/txpkt_fifo_chk.sv
module txpkt_fifo_chk #(
  parameter int BUF_BYTES = 2048,
  parameter int BC_W      = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            err_ack,
  input logic            o_valid,
  input logic            o_ready,
  input logic [7:0]      o_data,
  input logic            o_last,
  input logic            evt_txerr,
  input logic            evt_txemp,
  input logic [BC_W-1:0] fill
);
  a_r3_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    (fill[1:0] == 2'b00) && (fill <= BC_W'(BUF_BYTES)));

  a_r2_reject_keeps_fill: assert property (@(posedge clk) disable iff (rst)
    (evt_txerr && !$past(err_ack)) |-> (fill == $past(fill)));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

  a_r11_output_while_busy: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> busy);

  a_r9_empty_after_send: assert property (@(posedge clk) disable iff (rst)
    evt_txemp |-> (fill == '0 && !busy));
endmodule

bind txpkt_fifo txpkt_fifo_chk #(.BUF_BYTES(BUF_BYTES), .BC_W(BC_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .err_ack(err_ack), .o_valid(o_valid),
  .o_ready(o_ready), .o_data(o_data), .o_last(o_last),
  .evt_txerr(evt_txerr), .evt_txemp(evt_txemp), .fill(fill)
);

// File: tb/test_txpkt_fifo.sv
`timescale 1ns/1ps
module test_txpkt_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy, tx_req = 1'b0, err_ack = 1'b0;
  logic        pad_en = 1'b0, crc_auto = 1'b1;
  logic        thr_we = 1'b0;
  logic [5:0]  thr_wdata = '0, thr_q;
  logic        o_valid, o_last, o_ready = 1'b0;
  logic [7:0]  o_data;
  logic        evt_txerr, evt_txemp;

  txpkt_fifo i_txpkt_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
    .tx_req(tx_req), .err_ack(err_ack), .pad_en(pad_en), .crc_auto(crc_auto),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_q(thr_q),
    .o_valid(o_valid), .o_data(o_data), .o_last(o_last), .o_ready(o_ready),
    .evt_txerr(evt_txerr), .evt_txemp(evt_txemp)
  );

  int n_chk = 0, n_fail = 0, emp_cnt = 0, cyc = 0, mode = 0;
  bit finished = 0;
  logic [7:0] mbuf [0:2047];
  logic [7:0] expq [$];
  int mfill = 0, mlen = 0, thr_m = 63;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference monitor: ready pattern plus per-byte comparison each clock
  always @(negedge clk) begin
    cyc++;
    o_ready = (mode == 1) ? ((cyc % 3) != 0) : 1'b1;
    if (!rst && o_valid && o_ready) begin
      if (expq.size() == 0) chk(0, "R7 unexpected byte", o_data, 0);
      else begin
        automatic logic [7:0] e = expq.pop_front();
        chk(o_data == e, "R7 frame byte", o_data, e);
        chk(o_last == (expq.size() == 0), "R8 last flag", o_last, expq.size() == 0);
      end
    end
    if (!rst && evt_txemp) emp_cnt++;
  end

  function automatic bit model_launch();
    int need = mlen + 16 + (crc_auto ? 0 : 4);
    if (need > 2048) need = 2048;
    return (thr_m < 63) && (mfill >= 32 * thr_m + 4) && (mfill >= need);
  endfunction

  function automatic void build_frame();
    int flen = mlen + 14;
    if (pad_en && flen < 60) flen = 60;
    if (flen > 2046) flen = 2046;
    for (int off = 2; off < 2 + flen; off++)
      expq.push_back((off < mfill && off < mlen + 16) ? mbuf[off] : 8'h00);
    mfill = 0;
  endfunction

  task automatic wait_frame();
    int target = emp_cnt + 1;
    int guard = 0;
    while (emp_cnt < target && guard < 20000) begin @(posedge clk); guard++; end
    @(negedge clk);
    chk(expq.size() == 0, "R9 all bytes sent", expq.size(), 0);
    chk(!busy, "R9 busy drops after send", busy, 0);
  endtask

  task automatic idle_wait();
    do @(negedge clk); while (busy);
  endtask

  task automatic wr(input logic [31:0] w);
    bit err_exp, l_exp;
    idle_wait();
    wr_valid = 1'b1; wr_data = w;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
    err_exp = (mfill == 0) && (w[15:0] > 16'd2032);
    if (!err_exp && mfill + 4 <= 2048) begin
      if (mfill == 0) mlen = w[15:0];
      for (int b = 0; b < 4; b++) mbuf[mfill + b] = w[8*b +: 8];
      mfill += 4;
    end
    chk(evt_txerr == err_exp, "R2 length error event", evt_txerr, err_exp);
    if (!err_exp) begin
      chk(busy == 1'b1, "R11 busy after write", busy, 1);
      l_exp = model_launch();
      @(negedge clk);
      chk(busy == l_exp, "R5 launch decision", busy, l_exp);
      if (l_exp) begin build_frame(); wait_frame(); end
    end
  endtask

  task automatic send_req();
    idle_wait();
    tx_req = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_req = 1'b0;
    build_frame();
    wait_frame();
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_wdata = 6'(v);
    @(negedge clk);
    thr_we = 1'b0; thr_m = v;
    chk(thr_q == 6'(v), "R5 threshold readback", thr_q, v);
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'h9E37_79B9 * (k + 1);
  endfunction

  task automatic frame_words(input int len, input int nwords, input int seed);
    wr({16'hBE00 ^ 16'(seed), 16'(len)});
    for (int k = 1; k < nwords; k++) wr(pat(seed + k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 frame never completed actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(o_valid == 0, "R1 o_valid after reset", o_valid, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(evt_txerr == 0 && evt_txemp == 0, "R1 events after reset", {evt_txerr, evt_txemp}, 0);
    chk(thr_q == 6'h3F, "R1 threshold reset value", thr_q, 6'h3F);

    // R5: threshold disabled, no launch; R6 manual launch; R7 plain length
    frame_words(20, 11, 1);
    repeat (20) begin @(negedge clk); chk(!o_valid, "R5 no launch with threshold off", o_valid, 0); end
    send_req();
    // R9: fill is zero after a send, so a new manual launch sends zeros
    mlen = 20; send_req();

    // R7: padding, with stored check bytes at offsets 26..27 not sent
    pad_en = 1'b1; mode = 1;
    frame_words(10, 7, 40);
    send_req();
    pad_en = 1'b0; mode = 0;

    // R4/R5: automatic launch, threshold 0, auto check sequence on/off
    set_thr(0);
    crc_auto = 1'b1; frame_words(8, 6, 60);
    crc_auto = 1'b0; frame_words(8, 7, 70);
    crc_auto = 1'b1;

    // R5: threshold 2 delays launch until 68 bytes
    set_thr(2);
    mode = 1; frame_words(8, 17, 90); mode = 0;

    // R2: over-long length rejected; 2032 boundary accepted
    set_thr(63);
    wr(32'h0000_07F1);
    chk(busy == 0, "R2 rejected word leaves block idle", busy, 0);
    frame_words(4, 5, 120);
    send_req();
    frame_words(2032, 3, 130);
    send_req();

    // R10: acknowledge empties the buffer
    frame_words(6, 3, 150);
    @(negedge clk); err_ack = 1'b1; @(negedge clk); err_ack = 1'b0; mfill = 0;
    frame_words(4, 2, 160);
    send_req();

    // R11: a word presented while busy (check cycle) is ignored
    idle_wait();
    wr_valid = 1'b1; wr_data = 32'h5A5A_0020;
    @(posedge clk); @(negedge clk);
    chk(busy == 1, "R11 busy in check cycle", busy, 1);
    wr_data = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
    mlen = 32; mfill = 4; mbuf[0] = 8'h20; mbuf[1] = 8'h00; mbuf[2] = 8'h5A; mbuf[3] = 8'h5A;
    send_req();

    // R3: words beyond 2048 bytes dropped
    frame_words(2032, 515, 200);
    chk(mfill == 2048, "R3 model fill capped", mfill, 2048);
    mode = 1; send_req(); mode = 0;

    // R4: completeness need capped at 2048 with auto check sequence off
    crc_auto = 1'b0;
    set_thr(62);
    frame_words(2032, 512, 300);
    crc_auto = 1'b1;

    repeat (5) @(negedge clk);
    chk(emp_cnt == 12, "R9 empty event count", emp_cnt, 12);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule